// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer

This block is a 16-bit down counter with a reload latch, programmed through a small register write port. A free-running prescaler divides the main clock by one of eight power-of-two ratios. A slow-clock enable input can take its place as the count source. One counter serves several modes. In plain timer mode it counts prescaler ticks. In pulse mode and PWM mode it also drives a waveform pin. In event mode it counts edges of an external input. In pulse-width mode it counts ticks only while that input sits at a chosen level.

The external input first passes a sampling noise filter. An optional delay line then adds 0, 4, 8 or 16 clocks before edge detection. One two-bit field selects which edges are counted, which edges raise the input interrupt, and which level is measured. Every counter underflow reloads the counter from the latch and can raise a one-cycle underflow interrupt.

Register map: address 0 is the count value (bits 15:0). Address 1 is the mode register. Address 2 is the input control register. Address 3 is the prescaler select (bits 2:0). Every written value takes effect at the clock edge of the write.

Top module: `tmr_multi`

## Requirements
- R1: After reset the count value and the latch are 0xFFFF. The waveform pin, both interrupts and every register field are 0, which gives timer mode with a /16 ratio.
- R2: Prescaler select codes give these ratios: 0→16, 1→1, 2→2, 3→32, 4→64, 5→128, 6→256, 7→1024. A tick occurs at each edge where the number of cycles since reset, modulo the ratio, equals the ratio minus 1. In timer mode each tick decrements the count.
- R3: Mode bit 3 is the latch-only bit. When it is 0, a write to address 0 loads both the latch and the counter, and this load takes priority over counting. When it is 1, the write loads only the latch, and the counter takes the new value at its next reload.
- R4: An enabled count at value 0 reloads the counter from the latch. It also drives a one-cycle high pulse on irq_underflow in the following cycle. In PWM mode, see R8.
- R5: While mode bit 6 (stop) is 1, the count value is held in every mode.
- R6: While mode bit 4 is 1, the count source is the slow_en input instead of the prescaler tick.
- R7: Mode codes are held in mode bits 2:0. In pulse mode (code 1) and PWM mode (code 3), each underflow toggles tmr_out. A write to the mode register sets tmr_out to the written bit 7, which is the start level. In all other modes tmr_out stays unchanged.
- R8: In PWM mode an underflow raises irq_underflow only when it returns tmr_out to its start level, so the interrupt comes once per full period.
- R9: Event mode is code 4. The input edges selected by control bits 4:3 are counted: 00 rising, 01 falling, 10 and 11 both. When mode bit 5 (window) is 1, those edges are ignored and the count is held.
- R10: Pulse-width mode is code 5. The selected source is counted only while the filtered input is low when control bits 4:3 are 01, and only while it is high otherwise.
- R11: The filter samples cnt_pin every 2nd cycle. When control bit 0 is set, it samples every 4th cycle instead. The sample instants are at cycle counts that are odd, or that are 3 mod 4, respectively. The filtered level takes a new value only when three consecutive samples agree on it.
- R12: Control bits 2:1 delay the filtered level by 0, 4, 8 or 16 clocks before edges are detected.
- R13: irq_edge pulses for one cycle on the input edge after the edge occurs. The edge is falling for control bits 4:3 = 00, rising for 01, and either edge for 1x.
- R14: Mode codes 2, 6 and 7 behave as timer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| slow_en | input | 1 | Slow-clock count enable |
| cnt_pin | input | 1 | External count/measure input |
| count_value | output | 16 | Current counter value |
| tmr_out | output | 1 | Pulse/PWM waveform pin |
| irq_underflow | output | 1 | Underflow interrupt pulse |
| irq_edge | output | 1 | Input-edge interrupt pulse |

## Verification
A counter load or decrement appears on count_value at the edge that sees the write or the enable. The interrupts and tmr_out show their effect one register later, at that same edge. A pin change shows up only after the filter has taken three sample instants, plus one edge-detect register, plus the selected delay. The reference model in the bench advances on the same edge from the same inputs. It holds the filter history and the delay line as plain integers and arrays. All four outputs are compared at each falling edge, which comes after every register has settled and before the next stimulus is applied.

// File: rtl/tmr_multi_pkg.sv
package tmr_multi_pkg;

  localparam logic [2:0] MD_PULSE  = 3'd1;
  localparam logic [2:0] MD_PWM    = 3'd3;
  localparam logic [2:0] MD_EVENT  = 3'd4;
  localparam logic [2:0] MD_PWIDTH = 3'd5;

  localparam logic [1:0] RA_COUNT = 2'd0;
  localparam logic [1:0] RA_MODE  = 2'd1;
  localparam logic [1:0] RA_CTRL  = 2'd2;
  localparam logic [1:0] RA_PSC   = 2'd3;

  typedef struct packed {
    logic       out_start_hi;
    logic       stop;
    logic       win_block;
    logic       src_slow;
    logic       latch_only;
    logic [2:0] mode;
  } mode_reg_t;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic [1:0] dly_sel;
    logic       flt_div4;
  } ctrl_reg_t;

  // divide ratio from the non-monotonic select code
  function automatic int unsigned psc_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    return 16;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 32;
      3'd4:    return 64;
      3'd5:    return 128;
      3'd6:    return 256;
      default: return 1024;
    endcase
  endfunction

  // delay line length for the trigger delay code
  function automatic int dly_cycles(input logic [1:0] code);
    return (code == 2'd0) ? 0 : (2 << code);
  endfunction

  // edge selection: counting side or interrupt side of the edge field
  function automatic logic edge_pick(input logic [1:0] sel, input logic rise,
                                     input logic fall, input logic irq_side);
    if (sel[1]) return rise | fall;
    if (sel[0] ^ irq_side) return fall;
    return rise;
  endfunction

endpackage

// File: rtl/tmr_multi_psc.sv
module tmr_multi_psc
  import tmr_multi_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       flt_div4,
  output logic       tick,
  output logic       smp_en
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    mask   = PW'(psc_ratio(sel) - 32'd1);
    tick   = ((pre_q & mask) == mask);
    smp_en = flt_div4 ? (pre_q[1:0] == 2'b11) : pre_q[0];
  end
endmodule

// File: rtl/tmr_multi_flt.sv
module tmr_multi_flt
  import tmr_multi_pkg::*;
#(
  parameter int DLY_MAX = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       pin,
  input  logic [1:0] dly_sel,
  output logic       filt,
  output logic       lvl,
  output logic       rise,
  output logic       fall
);
  localparam int DW = DLY_MAX;

  logic [1:0]    hist_q;
  logic          filt_q;
  logic [DW-1:0] dl_q;
  logic          lvl_q;
  logic          agree;
  int            tap;

  always_comb begin
    agree = (hist_q == {2{pin}});
    tap   = dly_cycles(dly_sel);
    lvl   = filt_q;
    for (int k = 0; k < DW; k++) begin
      if (k + 1 == tap) lvl = dl_q[k];
    end
    rise = lvl & ~lvl_q;
    fall = ~lvl & lvl_q;
    filt = filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
      dl_q   <= '0;
      lvl_q  <= 1'b0;
    end else begin
      if (smp_en) begin
        hist_q <= {hist_q[0], pin};
        if (agree) filt_q <= pin;
      end
      dl_q  <= {dl_q[DW-2:0], filt_q};
      lvl_q <= lvl;
    end
  end
endmodule

// File: rtl/tmr_multi_core.sv
module tmr_multi_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_cnt,
  input  logic          wr_lat,
  input  logic [CW-1:0] wr_val,
  input  logic          wave_mode,
  input  logic          pwm_mode,
  input  logic          start_hi,
  input  logic          out_init,
  input  logic          init_lvl,
  output logic [CW-1:0] count,
  output logic [CW-1:0] latch,
  output logic          wave,
  output logic          uf_evt,
  output logic          irq_uf
);
  logic at_zero;

  always_comb begin
    at_zero = (count == '0);
    uf_evt  = cnt_en & at_zero & ~wr_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '1;
      latch  <= '1;
      wave   <= 1'b0;
      irq_uf <= 1'b0;
    end else begin
      if (wr_cnt)      count <= wr_val;
      else if (cnt_en) count <= at_zero ? latch : count - 1'b1;
      if (wr_lat) latch <= wr_val;
      if (out_init)                 wave <= init_lvl;
      else if (uf_evt && wave_mode) wave <= ~wave;
      irq_uf <= uf_evt & (~pwm_mode | (wave != start_hi));
    end
  end
endmodule

// File: rtl/tmr_multi.sv
module tmr_multi
  import tmr_multi_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PW      = 10,
  parameter int DLY_MAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          slow_en,
  input  logic          cnt_pin,
  output logic [CW-1:0] count_value,
  output logic          tmr_out,
  output logic          irq_underflow,
  output logic          irq_edge
);
  localparam int MW = $bits(mode_reg_t);
  localparam int XW = $bits(ctrl_reg_t);

  mode_reg_t     mode_q;
  ctrl_reg_t     ctl_q;
  logic [2:0]    psc_q;
  logic          tick, smp_en, filt, lvl, rise, fall;
  logic          src_tick, cnt_en, ctr_wr, lat_wr, mode_wr;
  logic          wave_mode, pwm_mode, event_mode, pwidth_mode;
  logic          uf_evt, stop_on, win_blk;
  logic [CW-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ctl_q    <= '0;
      psc_q    <= '0;
      irq_edge <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_reg_t'(wr_data[MW-1:0]);
      if (wr_en && wr_addr == RA_CTRL) ctl_q <= ctrl_reg_t'(wr_data[XW-1:0]);
      if (wr_en && wr_addr == RA_PSC)  psc_q <= wr_data[2:0];
      irq_edge <= edge_pick(ctl_q.edge_sel, rise, fall, 1'b1);
    end
  end

  always_comb begin
    mode_wr     = wr_en && wr_addr == RA_MODE;
    lat_wr      = wr_en && wr_addr == RA_COUNT;
    ctr_wr      = lat_wr && !mode_q.latch_only;
    pwm_mode    = mode_q.mode == MD_PWM;
    wave_mode   = pwm_mode || mode_q.mode == MD_PULSE;
    event_mode  = mode_q.mode == MD_EVENT;
    pwidth_mode = mode_q.mode == MD_PWIDTH;
    stop_on     = mode_q.stop;
    win_blk     = mode_q.win_block;
    src_tick    = mode_q.src_slow ? slow_en : tick;
    if (event_mode)
      cnt_en = edge_pick(ctl_q.edge_sel, rise, fall, 1'b0) & ~win_blk;
    else if (pwidth_mode)
      cnt_en = src_tick & (lvl == (ctl_q.edge_sel != 2'b01));
    else
      cnt_en = src_tick;
    cnt_en = cnt_en & ~stop_on;
  end

  tmr_multi_psc #(.PW(PW)) psc_i (
    .clk(clk), .rst_n(rst_n), .sel(psc_q), .flt_div4(ctl_q.flt_div4),
    .tick(tick), .smp_en(smp_en)
  );

  tmr_multi_flt #(.DLY_MAX(DLY_MAX)) flt_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .pin(cnt_pin),
    .dly_sel(ctl_q.dly_sel), .filt(filt), .lvl(lvl), .rise(rise), .fall(fall)
  );

  tmr_multi_core #(.CW(CW)) core_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_cnt(ctr_wr),
    .wr_lat(lat_wr), .wr_val(wr_data), .wave_mode(wave_mode),
    .pwm_mode(pwm_mode), .start_hi(mode_q.out_start_hi), .out_init(mode_wr),
    .init_lvl(wr_data[7]), .count(count_value), .latch(latch_q),
    .wave(tmr_out), .uf_evt(uf_evt), .irq_uf(irq_underflow)
  );
endmodule

// File: rtl/tmr_multi_chk.sv
module tmr_multi_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count_value,
  input logic [CW-1:0] latch_q,
  input logic          uf_evt,
  input logic          ctr_wr,
  input logic          stop_on,
  input logic          win_blk,
  input logic          event_mode,
  input logic          wave_mode,
  input logic          mode_wr,
  input logic          tmr_out,
  input logic          filt,
  input logic          smp_en,
  input logic          irq_underflow
);
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && !ctr_wr) |=> count_value == $past(latch_q));

  a_r4_irq_after_uf: assert property (@(posedge clk) disable iff (!rst_n)
    irq_underflow |-> $past(uf_evt));

  a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_on && !ctr_wr) |=> $stable(count_value));

  a_r9_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (event_mode && win_blk && !ctr_wr) |=> $stable(count_value));

  a_r7_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave_mode && !mode_wr) |=> $stable(tmr_out));

  a_r11_filter_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> $past(smp_en));
endmodule

bind tmr_multi tmr_multi_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .count_value(count_value), .latch_q(latch_q),
  .uf_evt(uf_evt), .ctr_wr(ctr_wr), .stop_on(stop_on), .win_blk(win_blk),
  .event_mode(event_mode), .wave_mode(wave_mode), .mode_wr(mode_wr),
  .tmr_out(tmr_out), .filt(filt), .smp_en(smp_en),
  .irq_underflow(irq_underflow)
);

// File: tb/tmr_multi_tb.sv
module tmr_multi_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        slow_en = 1'b0;
  logic        cnt_pin = 1'b0;
  logic [15:0] count_value;
  logic        tmr_out, irq_underflow, irq_edge;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  bit    slow_gen = 0;
  string req = "R1";

  always #10 clk = ~clk;

  tmr_multi dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slow_en(slow_en), .cnt_pin(cnt_pin),
    .count_value(count_value), .tmr_out(tmr_out),
    .irq_underflow(irq_underflow), .irq_edge(irq_edge)
  );

  // ---------------- behavioural reference model ----------------
  int          ratio_tab[8] = '{16, 1, 2, 32, 64, 128, 256, 1024};
  int          cyc;
  logic [15:0] m_cnt, m_lat;
  logic [7:0]  m_mode;
  logic [4:0]  m_ctl;
  logic [2:0]  m_psc;
  bit          m_out, m_iuf, m_ied, m_filt, m_lvld;
  bit          m_hist[2];
  bit          m_dl[16];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_cnt = 16'hFFFF; m_lat = 16'hFFFF; m_mode = 0; m_ctl = 0;
      m_psc = 0; m_out = 0; m_iuf = 0; m_ied = 0; m_filt = 0; m_lvld = 0;
      m_hist[0] = 0; m_hist[1] = 0;
      foreach (m_dl[i]) m_dl[i] = 0;
    end else begin
      int n, dcy, es, md;
      bit tick, smp, lvl, rs, fl, src, en, ldc, ldl, uf, nfilt;
      n    = ratio_tab[m_psc];
      tick = (cyc % n) == n - 1;                                   // R2
      smp  = m_ctl[0] ? (cyc % 4 == 3) : (cyc % 2 == 1);           // R11
      dcy  = (m_ctl[2:1] == 0) ? 0 : (4 << (m_ctl[2:1] - 1));      // R12
      lvl  = (dcy == 0) ? m_filt : m_dl[dcy-1];
      rs   = lvl && !m_lvld;
      fl   = !lvl && m_lvld;
      es   = m_ctl[4:3];
      md   = m_mode[2:0];
      src  = m_mode[4] ? slow_en : tick;                           // R6
      if (md == 4)      en = ((es == 0) ? rs : (es == 1) ? fl : (rs || fl)) && !m_mode[5];
      else if (md == 5) en = src && (lvl == (es != 1));            // R10
      else              en = src;                                  // R14
      en  = en && !m_mode[6];                                      // R5
      ldl = wr_en && wr_addr == 0;
      ldc = ldl && !m_mode[3];                                     // R3
      uf  = en && m_cnt == 0 && !ldc;
      m_iuf = uf && !(md == 3 && m_out == m_mode[7]);              // R4 R8
      m_ied = (es == 0) ? fl : (es == 1) ? rs : (rs || fl);        // R13
      if (ldc) m_cnt = wr_data;
      else if (en) m_cnt = (m_cnt == 0) ? m_lat : m_cnt - 16'd1;
      if (ldl) m_lat = wr_data;
      if (wr_en && wr_addr == 1) m_out = wr_data[7];               // R7
      else if (uf && (md == 1 || md == 3)) m_out = !m_out;
      for (int k = 15; k > 0; k--) m_dl[k] = m_dl[k-1];
      m_dl[0] = m_filt;
      nfilt = m_filt;
      if (smp) begin
        if (m_hist[0] == cnt_pin && m_hist[1] == cnt_pin) nfilt = cnt_pin;
        m_hist[1] = m_hist[0];
        m_hist[0] = cnt_pin;
      end
      m_filt = nfilt;
      m_lvld = lvl;
      if (wr_en && wr_addr == 1) m_mode = wr_data[7:0];
      if (wr_en && wr_addr == 2) m_ctl  = wr_data[4:0];
      if (wr_en && wr_addr == 3) m_psc  = wr_data[2:0];
      cyc = (cyc + 1) % 1024;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (count_value !== m_cnt || tmr_out !== m_out ||
          irq_underflow !== m_iuf || irq_edge !== m_ied) begin
        fails++;
        $display("FAIL %s: count=%h exp %h out=%b exp %b iuf=%b exp %b iedge=%b exp %b",
                 req, count_value, m_cnt, tmr_out, m_out, irq_underflow, m_iuf,
                 irq_edge, m_ied);
      end
    end
  end

  // slow enable: one pulse every third cycle when active
  int sdiv = 0;
  always @(negedge clk) begin
    #2;
    sdiv    = (sdiv + 1) % 3;
    slow_en = slow_gen && (sdiv == 0);
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_run(input bit v, input int n);
    @(negedge clk); #1;
    cnt_pin = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic toggles(input int n, input int len);
    for (int i = 0; i < n; i++) pin_run(!cnt_pin, len + (i % 4));
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual hung, expected done");
    finish_run();
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    checks++;
    if (count_value !== 16'hFFFF || tmr_out !== 0 || irq_underflow !== 0 || irq_edge !== 0) begin
      fails++;
      $display("FAIL R1: count=%h out=%b iuf=%b iedge=%b exp FFFF 0 0 0",
               count_value, tmr_out, irq_underflow, irq_edge);
    end
    rst_n = 1'b1;
    idle(40);

    // R2 R4: every prescaler ratio with a short reload
    req = "R2";
    for (int c = 0; c < 8; c++) begin
      wr(3, 16'(c));
      wr(0, 16'd3);
      idle((c == 7) ? 2100 : 300);
    end

    // R14: unused mode codes run as timer
    req = "R14";
    wr(3, 16'd1);
    wr(1, 16'h0002); wr(0, 16'd5); idle(30);
    wr(1, 16'h0006); idle(20);
    wr(1, 16'h0007); idle(20);

    // R3: latch-only write
    req = "R3";
    wr(1, 16'h0008); wr(3, 16'd2); wr(0, 16'd9); idle(50);
    wr(1, 16'h0000); wr(0, 16'd4); idle(20);

    // R5: stop holds the count
    req = "R5";
    wr(1, 16'h0040); idle(30);
    wr(0, 16'd7); idle(10);
    wr(1, 16'h0000); idle(20);

    // R6: slow-clock source
    req = "R6";
    slow_gen = 1; wr(1, 16'h0010); wr(0, 16'd6); idle(90);
    slow_gen = 0; idle(10);

    // R7: pulse output, start high then low
    req = "R7";
    wr(3, 16'd1); wr(1, 16'h0081); wr(0, 16'd4); idle(60);
    wr(1, 16'h0001); idle(40);

    // R8: PWM period interrupts
    req = "R8";
    wr(1, 16'h0083); wr(0, 16'd5); idle(80);
    wr(1, 16'h0003); idle(60);

    // R9 R13: event counting on each edge setting, then blocked window
    req = "R9";
    wr(1, 16'h0004); wr(0, 16'd6);
    for (int e = 0; e < 3; e++) begin
      wr(2, 16'(e << 3));
      toggles(10, 9);
    end
    req = "R13";
    wr(2, 16'h0008); toggles(6, 10);
    req = "R9";
    wr(1, 16'h0024); toggles(8, 10);

    // R11: glitches against both sampling rates
    req = "R11";
    wr(1, 16'h0004); wr(2, 16'h0010);
    for (int g = 1; g < 10; g++) begin pin_run(!cnt_pin, g); pin_run(!cnt_pin, 12); end
    wr(2, 16'h0011);
    for (int g = 2; g < 16; g += 2) begin pin_run(!cnt_pin, g); pin_run(!cnt_pin, 20); end

    // R12: each trigger delay
    req = "R12";
    for (int d = 1; d < 4; d++) begin
      wr(2, 16'h0010 | 16'(d << 1));
      toggles(6, 12);
    end

    // R10: pulse width on high then low level
    req = "R10";
    wr(2, 16'h0000); wr(3, 16'd1); wr(1, 16'h0005); wr(0, 16'h0100);
    pin_run(1, 40); pin_run(0, 30); pin_run(1, 25); pin_run(0, 20);
    wr(2, 16'h0008);
    pin_run(1, 40); pin_run(0, 30); pin_run(1, 25); pin_run(0, 20);
    idle(20);

    finish_run();
  end
endmodule